// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder and Aligner

This block sits between instruction fetch and decode. It receives a window of seven bytes taken from memory at the current program counter, with byte 0 at the lowest address. From the first byte it works out how long the instruction is, from one to seven bytes. For one opcode pair it also looks at the second byte to pick the layout. It then gathers the bytes into a 32-bit primary instruction word and an extension word, in the big-endian layout the decoder expects. Operand fields that sit little-endian in memory are reordered on the way.

The result is registered, so it appears one clock after the window is presented with the valid flag. Alongside the two words the block reports the length, an illegal-opcode flag, and the address of the following instruction. The fetch unit uses that address to advance. When the first byte is not a defined opcode, the address does not move.

Window byte k is carried on `in_window[8k+7:8k]`. In the requirements, bN means window byte N.

Top module: `ipa_predec`

## Requirements
- R1: While reset is asserted and on the first clock after it, out_valid, out_len, out_insn, out_ext, out_illegal and out_next_pc are all zero.
- R2: out_valid rises exactly one clock after a cycle with in_valid high and is low after a cycle with in_valid low. While out_valid is low, the other outputs keep the values of the last accepted window.
- R3: A first byte in 0x80..0xBF whose bits [3:2] equal bits [1:0] gives a 2-byte instruction with out_insn = {16'h0, b0, b1}. Every other first byte in that range gives a 1-byte instruction.
- R4: A 1-byte instruction gives out_insn = {24'h0, b0} and out_ext = 0. The 1-byte first bytes are 00, 04, 08, 0C, 10..1F, 3C..41, 44, 45, 48, 49, 4C, 4D, 50..57, 60..7F, CB, D0..DB, E0..EF and FF.
- R5: The first bytes 20..23, 28..2B, 42, 43, 46, 47, 4A, 4B, 4E, 4F, 58..5F, C0..CA, CE, CF and F0..F6 are 2 bytes long, with out_insn = {16'h0, b0, b1} and out_ext = 0.
- R6: The first bytes 01..03, 05..07, 09..0B, 0D..0F, 24..27, 2C..3B and CC are 3 bytes long. Bytes b1 and b2 hold a little-endian 16-bit operand, and out_insn = {8'h0, b0, b2, b1}.
- R7: The first bytes DE, DF, F8 and F9 are 3 bytes long, with out_insn = {8'h0, b0, b1, b2}.
- R8: The first bytes FA and FB are 4 bytes long.
  - When (b1 & 0xFC) is F0, F4 or F8: out_insn = {b0, b1, b2, b3}.
  - Otherwise: out_insn = {b0, b1, b3, b2}.
- R9: The first bytes CD and DC are 5 bytes long.
  - CD: out_insn = {b0, b2, b1, b3}, out_ext = b4.
  - DC: out_insn = {b0, b4, b3, b2}, out_ext = b1.
- R10: The first bytes FC and FD are 6 bytes long, with out_insn = {b0, b1, b5, b4} and out_ext = {16'h0, b3, b2}.
- R11: The first bytes DD and FE are 7 bytes long.
  - DD: out_insn = {b0, b4, b3, b2}, out_ext = {8'h0, b1, b5, b6}.
  - FE: out_insn = {b0, b1, b5, b4}, out_ext = {8'h0, b3, b2, b6}.
- R12: First byte F7 is the only undefined opcode. It gives out_illegal = 1, out_len = 0, out_insn = 0, out_ext = 0 and out_next_pc equal to the presented PC. Every other first byte gives out_illegal = 0.
- R13: out_next_pc equals the presented PC plus out_len, wrapping modulo 2^PC_W.
- R14: In every unused upper byte of out_insn and out_ext, the value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window and PC are valid this cycle |
| in_pc | input | PC_W | Address of window byte 0 |
| in_window | input | 56 | Seven fetched bytes, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Registered result is new this cycle |
| out_len | output | 3 | Instruction length in bytes, 0 when illegal |
| out_insn | output | 32 | Primary instruction word, big-endian layout |
| out_ext | output | 32 | Extension word |
| out_illegal | output | 1 | First byte is not a defined opcode |
| out_next_pc | output | PC_W | Presented PC plus length |

## Verification
A wrong format class shows at the ports on the very next clock, in two ways: a length that differs, and a byte order in out_insn or out_ext that does not match, often both together. Because next PC follows from the length, a wrong class also moves the fetch address in that same cycle. A byte-swap slip in a single layout shows only for the first bytes of that class. Among those, the FA/FB pair also needs second bytes on both sides of the mask test. The stimulus therefore mixes random windows with forced picks from every class and with both sides of that mask test.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WIN_BYTES = 7;
  localparam int unsigned WIN_W     = BYTE_W * WIN_BYTES;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 3;

  typedef enum logic [3:0] {
    FMT_ILL,
    FMT_B1,
    FMT_B2,
    FMT_B3_LE,
    FMT_B3_BE,
    FMT_B4_BE,
    FMT_B4_MIX,
    FMT_B5_MID,
    FMT_B5_WRD,
    FMT_B6,
    FMT_B7_WRD,
    FMT_B7_HLF
  } fmt_e;

  // First-byte class map; the second byte only matters for the FA/FB pair.
  function automatic fmt_e classify(input logic [7:0] b0, input logic [7:0] b1);
    logic [3:0] hi;
    logic [3:0] lo;
    logic [7:0] sel;
    fmt_e f;
    hi  = b0[7:4];
    lo  = b0[3:0];
    sel = b1 & 8'hFC;
    f   = FMT_B1;
    case (hi)
      4'h0: f = (lo[1:0] == 2'b00) ? FMT_B1 : FMT_B3_LE;
      4'h1: f = FMT_B1;
      4'h2: f = lo[2] ? FMT_B3_LE : FMT_B2;
      4'h3: f = (lo >= 4'hC) ? FMT_B1 : FMT_B3_LE;
      4'h4: f = lo[1] ? FMT_B2 : FMT_B1;
      4'h5: f = lo[3] ? FMT_B2 : FMT_B1;
      4'h6, 4'h7: f = FMT_B1;
      4'h8, 4'h9, 4'hA, 4'hB:
        f = (lo[3:2] == lo[1:0]) ? FMT_B2 : FMT_B1;
      4'hC: begin
        case (lo)
          4'hB:    f = FMT_B1;
          4'hC:    f = FMT_B3_LE;
          4'hD:    f = FMT_B5_MID;
          default: f = FMT_B2;
        endcase
      end
      4'hD: begin
        case (lo)
          4'hC:       f = FMT_B5_WRD;
          4'hD:       f = FMT_B7_WRD;
          4'hE, 4'hF: f = FMT_B3_BE;
          default:    f = FMT_B1;
        endcase
      end
      4'hE: f = FMT_B1;
      default: begin
        case (lo)
          4'h7:       f = FMT_ILL;
          4'h8, 4'h9: f = FMT_B3_BE;
          4'hA, 4'hB: f = (sel == 8'hF0 || sel == 8'hF4 || sel == 8'hF8)
                          ? FMT_B4_BE : FMT_B4_MIX;
          4'hC, 4'hD: f = FMT_B6;
          4'hE:       f = FMT_B7_HLF;
          4'hF:       f = FMT_B1;
          default:    f = FMT_B2;
        endcase
      end
    endcase
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] fmt_len(input fmt_e f);
    case (f)
      FMT_B1:                               return 3'd1;
      FMT_B2:                               return 3'd2;
      FMT_B3_LE, FMT_B3_BE:                 return 3'd3;
      FMT_B4_BE, FMT_B4_MIX:                return 3'd4;
      FMT_B5_MID, FMT_B5_WRD:               return 3'd5;
      FMT_B6:                               return 3'd6;
      FMT_B7_WRD, FMT_B7_HLF:               return 3'd7;
      default:                              return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ipa_len_classify.sv
module ipa_len_classify
  import ipa_pkg::*;
(
  input  logic [7:0]       b0,
  input  logic [7:0]       b1,
  output fmt_e             fmt,
  output logic [LEN_W-1:0] len,
  output logic             illegal
);

  always_comb begin
    fmt     = classify(b0, b1);
    len     = fmt_len(fmt);
    illegal = (fmt == FMT_ILL);
  end

endmodule

// File: rtl/ipa_word_pack.sv
module ipa_word_pack
  import ipa_pkg::*;
(
  input  fmt_e                          fmt,
  input  logic [WIN_BYTES-1:0][7:0]     bytes_in,
  output logic [WORD_W-1:0]             insn,
  output logic [WORD_W-1:0]             ext
);

  logic [7:0] b0, b1, b2, b3, b4, b5, b6;

  always_comb begin
    b0 = bytes_in[0];
    b1 = bytes_in[1];
    b2 = bytes_in[2];
    b3 = bytes_in[3];
    b4 = bytes_in[4];
    b5 = bytes_in[5];
    b6 = bytes_in[6];
    insn = '0;
    ext  = '0;
    case (fmt)
      FMT_B1:     insn = {24'h0, b0};
      FMT_B2:     insn = {16'h0, b0, b1};
      FMT_B3_LE:  insn = {8'h0, b0, b2, b1};
      FMT_B3_BE:  insn = {8'h0, b0, b1, b2};
      FMT_B4_BE:  insn = {b0, b1, b2, b3};
      FMT_B4_MIX: insn = {b0, b1, b3, b2};
      FMT_B5_MID: begin
        insn = {b0, b2, b1, b3};
        ext  = {24'h0, b4};
      end
      FMT_B5_WRD: begin
        insn = {b0, b4, b3, b2};
        ext  = {24'h0, b1};
      end
      FMT_B6: begin
        insn = {b0, b1, b5, b4};
        ext  = {16'h0, b3, b2};
      end
      FMT_B7_WRD: begin
        insn = {b0, b4, b3, b2};
        ext  = {8'h0, b1, b5, b6};
      end
      FMT_B7_HLF: begin
        insn = {b0, b1, b5, b4};
        ext  = {8'h0, b3, b2, b6};
      end
      default: begin
        insn = '0;
        ext  = '0;
      end
    endcase
  end

endmodule

// File: rtl/ipa_pc_step.sv
module ipa_pc_step
  import ipa_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  next_pc
);

  always_comb next_pc = pc + PC_W'(len);

endmodule

// File: rtl/ipa_predec.sv
module ipa_predec
  import ipa_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [PC_W-1:0]      in_pc,
  input  logic [WIN_W-1:0]     in_window,
  output logic                 out_valid,
  output logic [LEN_W-1:0]     out_len,
  output logic [WORD_W-1:0]    out_insn,
  output logic [WORD_W-1:0]    out_ext,
  output logic                 out_illegal,
  output logic [PC_W-1:0]      out_next_pc
);

  logic [WIN_BYTES-1:0][7:0] win_b;
  fmt_e                      cls_fmt;
  logic [LEN_W-1:0]          cls_len;
  logic                      cls_illegal;
  logic [WORD_W-1:0]         pk_insn;
  logic [WORD_W-1:0]         pk_ext;
  logic [PC_W-1:0]           step_pc;

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_split
    assign win_b[k] = in_window[k*BYTE_W +: BYTE_W];
  end

  ipa_len_classify u_cls (
    .b0      (win_b[0]),
    .b1      (win_b[1]),
    .fmt     (cls_fmt),
    .len     (cls_len),
    .illegal (cls_illegal)
  );

  ipa_word_pack u_pack (
    .fmt      (cls_fmt),
    .bytes_in (win_b),
    .insn     (pk_insn),
    .ext      (pk_ext)
  );

  ipa_pc_step #(.PC_W(PC_W)) u_step (
    .pc      (in_pc),
    .len     (cls_len),
    .next_pc (step_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_len     <= '0;
      out_insn    <= '0;
      out_ext     <= '0;
      out_illegal <= 1'b0;
      out_next_pc <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_len     <= cls_len;
        out_insn    <= pk_insn;
        out_ext     <= pk_ext;
        out_illegal <= cls_illegal;
        out_next_pc <= step_pc;
      end
    end
  end

endmodule

// File: rtl/ipa_predec_chk.sv
module ipa_predec_chk
  import ipa_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PC_W-1:0]   in_pc,
  input logic [WIN_W-1:0]  in_window,
  input logic              out_valid,
  input logic [LEN_W-1:0]  out_len,
  input logic [WORD_W-1:0] out_insn,
  input logic [WORD_W-1:0] out_ext,
  input logic              out_illegal,
  input logic [PC_W-1:0]   out_next_pc,
  input logic              cls_illegal
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_insn) && $stable(out_ext) && $stable(out_len)));

  p_len_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_len != 3'd0));

  p_next_pc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_next_pc == $past(in_pc) + PC_W'(out_len)));

  p_illegal_only_f7_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_illegal == ($past(in_window[7:0]) == 8'hF7)));

  p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == 3'd0 && out_insn == '0 && out_ext == '0));

  p_one_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 3'd1) |-> (out_ext == '0 && out_insn[31:8] == 24'h0));

  p_short_ext_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len <= 3'd4) |-> (out_ext == '0));

  p_flag_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_illegal == $past(cls_illegal)));

endmodule

bind ipa_predec ipa_predec_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_pc       (in_pc),
  .in_window   (in_window),
  .out_valid   (out_valid),
  .out_len     (out_len),
  .out_insn    (out_insn),
  .out_ext     (out_ext),
  .out_illegal (out_illegal),
  .out_next_pc (out_next_pc),
  .cls_illegal (cls_illegal)
);

// File: tb/tb_ipa_predec.sv
`timescale 1ns/1ps
module tb_ipa_predec;

  localparam int PC_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic [55:0] in_window = '0;
  logic        out_valid;
  logic [2:0]  out_len;
  logic [31:0] out_insn;
  logic [31:0] out_ext;
  logic        out_illegal;
  logic [31:0] out_next_pc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipa_predec #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .in_window(in_window), .out_valid(out_valid), .out_len(out_len),
    .out_insn(out_insn), .out_ext(out_ext), .out_illegal(out_illegal),
    .out_next_pc(out_next_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [7:0] b0);
    if (b0 == 8'hF7) return 0;
    if (b0 inside {[8'h80:8'hBF]}) return (b0[3:2] == b0[1:0]) ? 2 : 1;
    if (b0 inside {[8'h20:8'h23], [8'h28:8'h2B], 8'h42, 8'h43, 8'h46, 8'h47,
                   8'h4A, 8'h4B, 8'h4E, 8'h4F, [8'h58:8'h5F], [8'hC0:8'hCA],
                   8'hCE, 8'hCF, [8'hF0:8'hF6]}) return 2;
    if (b0 inside {[8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0B], [8'h0D:8'h0F],
                   [8'h24:8'h27], [8'h2C:8'h3B], 8'hCC,
                   8'hDE, 8'hDF, 8'hF8, 8'hF9}) return 3;
    if (b0 inside {8'hFA, 8'hFB}) return 4;
    if (b0 inside {8'hCD, 8'hDC}) return 5;
    if (b0 inside {8'hFC, 8'hFD}) return 6;
    if (b0 inside {8'hDD, 8'hFE}) return 7;
    return 1;
  endfunction

  function automatic string ref_tag(input logic [7:0] b0);
    int n;
    n = ref_len(b0);
    if (b0 inside {[8'h80:8'hBF]}) return "R3";
    if (n == 0) return "R12";
    if (n == 1) return "R4";
    if (n == 2) return "R5";
    if (n == 3) return (b0 inside {8'hDE, 8'hDF, 8'hF8, 8'hF9}) ? "R7" : "R6";
    if (n == 4) return "R8";
    if (n == 5) return "R9";
    if (n == 6) return "R10";
    return "R11";
  endfunction

  // Expected words from little-endian operand reads, restated per layout.
  task automatic ref_words(input logic [55:0] w, output logic [31:0] ei, output logic [31:0] ee);
    logic [7:0]  b [7];
    logic [31:0] w_at1, w_at2;
    logic [15:0] h_at1;
    int n;
    for (int k = 0; k < 7; k++) b[k] = w[8*k +: 8];
    h_at1 = 16'(b[1]) | (16'(b[2]) << 8);
    w_at1 = 32'(b[1]) | (32'(b[2]) << 8) | (32'(b[3]) << 16) | (32'(b[4]) << 24);
    w_at2 = 32'(b[2]) | (32'(b[3]) << 8) | (32'(b[4]) << 16) | (32'(b[5]) << 24);
    n = ref_len(b[0]);
    ee = 0;
    ei = 0;
    case (n)
      1: ei = 32'(b[0]);
      2: ei = (32'(b[0]) << 8) | 32'(b[1]);
      3: if (b[0] inside {8'hDE, 8'hDF, 8'hF8, 8'hF9})
           ei = (32'(b[0]) << 16) | (32'(b[1]) << 8) | 32'(b[2]);
         else
           ei = (32'(b[0]) << 16) | 32'(h_at1);
      4: if ((b[1] & 8'hFC) inside {8'hF0, 8'hF4, 8'hF8})
           ei = {b[0], b[1], b[2], b[3]};
         else
           ei = (32'({b[0], b[1]}) << 16) | 32'(w_at2[15:0]);
      5: if (b[0] == 8'hCD) begin
           ei = (32'(b[0]) << 24) | (32'(h_at1) << 8) | 32'(b[3]);
           ee = 32'(b[4]);
         end else begin
           ei = (32'(b[0]) << 24) | (w_at1 >> 8);
           ee = w_at1 & 32'hFF;
         end
      6: begin
           ei = (32'({b[0], b[1]}) << 16) | (w_at2 >> 16);
           ee = w_at2 & 32'hFFFF;
         end
      7: if (b[0] == 8'hDD) begin
           ei = (32'(b[0]) << 24) | (w_at1 >> 8);
           ee = ((w_at1 & 32'hFF) << 16) | (32'(b[5]) << 8) | 32'(b[6]);
         end else begin
           ei = (32'({b[0], b[1]}) << 16) | (w_at2 >> 16);
           ee = ((w_at2 & 32'hFFFF) << 8) | 32'(b[6]);
         end
      default: ;
    endcase
  endtask

  task automatic run_vec(input logic [55:0] w, input logic [31:0] pc);
    logic [31:0] ei, ee;
    int n;
    string t;
    @(negedge clk);
    in_window = w;
    in_pc     = pc;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    n = ref_len(w[7:0]);
    t = ref_tag(w[7:0]);
    ref_words(w, ei, ee);
    chk({"R2 valid ", t}, 32'(out_valid), 32'd1);
    chk({t, " len"}, 32'(out_len), 32'(n));
    chk({t, " insn"}, out_insn, ei);
    chk({t, " ext R14"}, out_ext, ee);
    chk({"R12 flag ", t}, 32'(out_illegal), (n == 0) ? 32'd1 : 32'd0);
    chk({"R13 next_pc ", t}, out_next_pc, pc + 32'(n));
  endtask

  task automatic idle_check();
    logic [31:0] held_i, held_e;
    held_i = out_insn;
    held_e = out_ext;
    in_window = {$urandom, $urandom};
    @(negedge clk);
    chk("R2 idle valid", 32'(out_valid), 32'd0);
    chk("R2 idle hold insn", out_insn, held_i);
    chk("R2 idle hold ext", out_ext, held_e);
  endtask

  function automatic logic [55:0] mk(input logic [7:0] b0, input logic [7:0] b1);
    logic [55:0] w;
    w = {$urandom, $urandom};
    w[7:0]  = b0;
    w[15:8] = b1;
    return w;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 len", 32'(out_len), 0);
    chk("R1 insn", out_insn, 0);
    chk("R1 ext", out_ext, 0);
    chk("R1 illegal", 32'(out_illegal), 0);
    chk("R1 next_pc", out_next_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(out_valid), 0);

    // Directed corners: fixed windows per layout
    run_vec(56'h66_55_44_33_22_11_85, 32'h100);   // R3 equal fields
    run_vec(56'h66_55_44_33_22_11_86, 32'h100);   // R3 unequal fields
    run_vec(56'h66_55_44_33_22_11_CB, 32'h200);   // R4
    run_vec(56'h66_55_44_33_22_11_F6, 32'h200);   // R5
    run_vec(56'h66_55_44_33_22_11_CC, 32'h300);   // R6
    run_vec(56'h66_55_44_33_22_11_DE, 32'h300);   // R7
    run_vec(56'h66_55_44_33_22_F4_FA, 32'h400);   // R8 big-endian side
    run_vec(56'h66_55_44_33_22_FC_FB, 32'h400);   // R8 mixed side
    run_vec(56'h66_55_44_33_22_11_CD, 32'h500);   // R9
    run_vec(56'h66_55_44_33_22_11_DC, 32'h500);   // R9
    run_vec(56'h66_55_44_33_22_11_FD, 32'h600);   // R10
    run_vec(56'h66_55_44_33_22_11_DD, 32'h700);   // R11
    run_vec(56'h66_55_44_33_22_11_FE, 32'h700);   // R11
    run_vec(56'h66_55_44_33_22_11_F7, 32'h800);   // R12 pc holds
    run_vec(56'h66_55_44_33_22_11_FE, 32'hFFFF_FFFE); // R13 wrap
    idle_check();

    // Full sweep of first bytes
    for (int v = 0; v < 256; v++) run_vec(mk(8'(v), 8'($urandom)), $urandom);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b0, b1;
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      if ($urandom % 6 == 0) begin
        b0 = ($urandom % 2 == 0) ? 8'hFA : 8'hFB;
        b1 = 8'hF0 + 8'($urandom % 16);
      end
      run_vec(mk(b0, b1), $urandom);
      if ($urandom % 4 == 0) idle_check();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule